// File: doc/BRIEF.md
# Mode-Change Reconfiguration Controller

This controller decides when the output timing path of a video bridge gets rebuilt. It watches a stream of detected input-mode codes and control-plane events: a hot-plug change and a display-capability update. It starts a reconfiguration only when one of those triggers is present. A new input mode is accepted only after it has been seen on a programmable number of consecutive valid detect samples. A lock setting can pin the output to one fixed mode, and input changes are then ignored.

Each reconfiguration follows a fixed order. Blank is raised first. The controller waits for a frame boundary, then sends a one-cycle strobe that carries the new mode. It then waits for the downstream timing path to report done, and only after that releases blank. If done does not come within a timeout, a sticky error flag is set and the controller parks in a blanked idle state until the next trigger.

Saturating counters record reconfigurations, buffer underflows, buffer overflows and watermark hits. A clear pulse zeroes all counters and the error flag together.

The sequencer has five states:

| State | Blank | Meaning |
|---|---|---|
| ST_HALT | high | Blanked idle. This is the state after reset and after a timeout. |
| ST_RUN | low | Video is live. |
| ST_ARM | high | Blank is raised and the controller waits for a frame boundary. |
| ST_STROBE | high | The strobe is issued for one cycle. |
| ST_WAIT | high | The controller waits for done or for the timeout. |

The transitions are:

| From | To | Condition |
|---|---|---|
| ST_HALT or ST_RUN | ST_ARM | A trigger is present or pending. |
| ST_ARM | ST_STROBE | `frame_tick` is high. |
| ST_STROBE | ST_WAIT | Always, after one cycle. |
| ST_WAIT | ST_RUN | `tg_done` is high. |
| ST_WAIT | ST_HALT | The timeout expires without `tg_done`. |

Top module: `mode_reconfig_ctrl`

## Requirements
- R1: After reset, the outputs are in this state: `blank`=1, `reconf_pulse`=0, `err_timeout`=0, `cur_mode`=DEF_MODE, and every counter is 0.
- R2: A detected mode is accepted only after it appears on `cfg_runs` consecutive samples with `det_valid`=1. A value of 0 counts as 1. Cycles with `det_valid`=0 neither count toward the run nor break it.
- R3: A reconfiguration starts only on one of these triggers:
  - a change of the target mode (an accepted detect change, or a change of the lock settings);
  - an `hpd_evt` pulse;
  - an `edid_evt` pulse.
- R4: Each trigger produces exactly one `reconf_pulse`, and that pulse lasts one cycle. A short glitch that returns to the accepted mode produces none.
- R5: `blank` rises before the strobe. `reconf_pulse` appears only in the cycle after a `frame_tick` seen in ST_ARM. `blank` falls only after `tg_done`.
- R6: If `tg_done` does not arrive within TIMEOUT cycles of ST_WAIT, `err_timeout` is set and stays set. The controller returns to ST_HALT with `blank` held high until the next trigger.
- R7: With `cfg_lock`=1, the target mode is `cfg_lock_mode`, and changes on the detect input cause no reconfiguration.
- R8: Each cycle in which `buf_underflow`, `buf_overflow` or `buf_watermark` is high adds one to its own counter. Each strobe adds one to `cnt_reconfig`. All counters saturate at their all-ones value.
- R9: `stat_clear` zeroes all four counters and `err_timeout` on the next clock edge.
- R10: `reconf_mode` and `cur_mode` carry the target mode latched at the frame boundary. While in ST_RUN with no trigger pending, `cur_mode` equals the current target mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_mode | input | MODE_W | Detected input mode code |
| det_valid | input | 1 | `det_mode` holds a new sample |
| hpd_evt | input | 1 | Hot-plug change pulse |
| edid_evt | input | 1 | Capability-data update pulse |
| frame_tick | input | 1 | Output frame boundary pulse |
| tg_done | input | 1 | Timing path finished reconfiguring |
| buf_underflow | input | 1 | Buffer underflow event |
| buf_overflow | input | 1 | Buffer overflow event |
| buf_watermark | input | 1 | Buffer watermark hit |
| cfg_runs | input | RUN_W | Required consecutive matching samples |
| cfg_lock | input | 1 | Force a fixed output mode |
| cfg_lock_mode | input | MODE_W | Mode used while locked |
| stat_clear | input | 1 | Clear the counters and the error flag |
| blank | output | 1 | Blanking request |
| reconf_pulse | output | 1 | One-cycle reconfigure strobe |
| reconf_mode | output | MODE_W | Mode carried by the strobe |
| cur_mode | output | MODE_W | Mode most recently applied |
| err_timeout | output | 1 | Sticky timeout flag |
| cnt_reconfig | output | CNT_W | Reconfiguration count |
| cnt_underflow | output | CNT_W | Underflow count |
| cnt_overflow | output | CNT_W | Overflow count |
| cnt_watermark | output | CNT_W | Watermark count |

## Verification
A corrupted debounce run shows up at the ports within one detect sample. It appears either as a strobe the scoreboard did not expect, or as a missing strobe after the run length is met. A sequencer stuck in the wrong state shows up within a few cycles as `blank` at the wrong level, or as a strobe with no frame boundary before it. A lost pending trigger leaves `cur_mode` different from the target while `blank` is low. The bench compares every strobe's mode against a queue of expected modes and checks `blank` before and after each frame boundary and each done.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
    typedef enum logic [2:0] {
        ST_HALT,
        ST_RUN,
        ST_ARM,
        ST_STROBE,
        ST_WAIT
    } mrc_state_e;

    localparam int unsigned NUM_CNT = 4;
    localparam int unsigned IDX_RECONF = 0;
    localparam int unsigned IDX_UNDER  = 1;
    localparam int unsigned IDX_OVER   = 2;
    localparam int unsigned IDX_WMARK  = 3;
endpackage

// File: rtl/mrc_qualifier.sv
module mrc_qualifier #(
    parameter int unsigned MODE_W   = 4,
    parameter int unsigned RUN_W    = 4,
    parameter int unsigned DEF_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] det_mode,
    input  logic              det_valid,
    input  logic [RUN_W-1:0]  cfg_runs,
    output logic [MODE_W-1:0] stable_mode
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [MODE_W-1:0] cand_q;
    logic [MODE_W-1:0] stable_q;
    logic [RUN_W-1:0]  run_q;
    logic [RUN_W-1:0]  run_nx;
    logic [RUN_W-1:0]  need_runs;
    logic              same_cand;

    always_comb begin
        need_runs = (cfg_runs == '0) ? RUN_W'(1) : cfg_runs;
        same_cand = (det_mode == cand_q);
        if (!same_cand) begin
            run_nx = RUN_W'(1);
        end else if (run_q == RUN_MAX) begin
            run_nx = run_q;
        end else begin
            run_nx = run_q + RUN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q   <= MODE_W'(DEF_MODE);
            stable_q <= MODE_W'(DEF_MODE);
            run_q    <= '0;
        end else if (det_valid) begin
            cand_q <= det_mode;
            run_q  <= run_nx;
            if (run_nx == need_runs) begin
                stable_q <= det_mode;
            end
        end
    end

    assign stable_mode = stable_q;

    // R2: the accepted mode never moves on a cycle without a detect sample
    a_r2_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !det_valid |=> $stable(stable_mode));

    // R2: a newly accepted value equals the sample that completed its run
    a_r2_accept_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && det_mode != stable_mode) |=> (stable_mode == $past(det_mode) || $stable(stable_mode)));
endmodule

// File: rtl/mrc_sat_counter.sv
module mrc_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (inc && count_q != CNT_MAX) begin
            count_q <= count_q + W'(1);
        end
    end

    assign count = count_q;

    // R8: a full counter stays full until cleared
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> count == CNT_MAX);

    // R9: clear empties the counter on the next edge
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    // R8: without inc or clear the count holds
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/mrc_sequencer.sv
module mrc_sequencer
    import mrc_pkg::*;
#(
    parameter int unsigned MODE_W   = 4,
    parameter int unsigned TIMEOUT  = 32,
    parameter int unsigned DEF_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] target_mode,
    input  logic              hpd_evt,
    input  logic              edid_evt,
    input  logic              frame_tick,
    input  logic              tg_done,
    input  logic              err_clr,
    output logic              blank,
    output logic              reconf_pulse,
    output logic [MODE_W-1:0] reconf_mode,
    output logic [MODE_W-1:0] cur_mode,
    output logic              err_timeout
);
    localparam int unsigned TMR_W = $clog2(TIMEOUT + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

    mrc_state_e        state_q, state_d;
    logic [MODE_W-1:0] target_q;
    logic [MODE_W-1:0] cur_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              pending_q;
    logic              err_q;
    logic              trig;
    logic              go;
    logic              idle_st;
    logic              expire;

    always_comb begin
        trig    = (target_mode != target_q) || hpd_evt || edid_evt;
        go      = trig || pending_q;
        idle_st = (state_q == ST_HALT) || (state_q == ST_RUN);
        expire  = (state_q == ST_WAIT) && !tg_done && (tmr_q == TMR_LAST);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:   if (go) state_d = ST_ARM;
            ST_RUN:    if (go) state_d = ST_ARM;
            ST_ARM:    if (frame_tick) state_d = ST_STROBE;
            ST_STROBE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (tg_done) begin
                    state_d = ST_RUN;
                end else if (expire) begin
                    state_d = ST_HALT;
                end
            end
            default:   state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q  <= MODE_W'(DEF_MODE);
            cur_q     <= MODE_W'(DEF_MODE);
            tmr_q     <= '0;
            pending_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            target_q <= target_mode;
            if (idle_st && go) begin
                pending_q <= 1'b0;
            end else if (trig) begin
                pending_q <= 1'b1;
            end
            if (state_q == ST_ARM && frame_tick) begin
                cur_q <= target_mode;
            end
            if (state_q == ST_WAIT) begin
                tmr_q <= tmr_q + TMR_W'(1);
            end else begin
                tmr_q <= '0;
            end
            if (err_clr) begin
                err_q <= 1'b0;
            end else if (expire) begin
                err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        blank        = (state_q != ST_RUN);
        reconf_pulse = (state_q == ST_STROBE);
        reconf_mode  = cur_q;
        cur_mode     = cur_q;
        err_timeout  = err_q;
    end

    // R5: a strobe follows a frame boundary
    a_r5_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_pulse |-> $past(frame_tick));

    // R5: blank releases only after done
    a_r5_unblank_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank) |-> $past(tg_done));

    // R4: the strobe is a single cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_pulse |=> !reconf_pulse);

    // R3: blank rises only on a trigger or a pending one
    a_r3_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank) |-> $past(trig || pending_q));

    // R6: the timeout flag is sticky until cleared
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout && !err_clr) |=> err_timeout);

    // R6: a timeout leaves the output blanked
    a_r6_halt_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (blank && state_q == ST_HALT));

    // R10: live output never runs on a stale mode
    a_r10_no_stale_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !pending_q && !trig) |-> cur_mode == target_mode);
endmodule

// File: rtl/mode_reconfig_ctrl.sv
module mode_reconfig_ctrl
    import mrc_pkg::*;
#(
    parameter int unsigned MODE_W   = 4,
    parameter int unsigned RUN_W    = 4,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned TIMEOUT  = 32,
    parameter int unsigned DEF_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] det_mode,
    input  logic              det_valid,
    input  logic              hpd_evt,
    input  logic              edid_evt,
    input  logic              frame_tick,
    input  logic              tg_done,
    input  logic              buf_underflow,
    input  logic              buf_overflow,
    input  logic              buf_watermark,
    input  logic [RUN_W-1:0]  cfg_runs,
    input  logic              cfg_lock,
    input  logic [MODE_W-1:0] cfg_lock_mode,
    input  logic              stat_clear,
    output logic              blank,
    output logic              reconf_pulse,
    output logic [MODE_W-1:0] reconf_mode,
    output logic [MODE_W-1:0] cur_mode,
    output logic              err_timeout,
    output logic [CNT_W-1:0]  cnt_reconfig,
    output logic [CNT_W-1:0]  cnt_underflow,
    output logic [CNT_W-1:0]  cnt_overflow,
    output logic [CNT_W-1:0]  cnt_watermark
);
    logic [MODE_W-1:0] stable_mode;
    logic [MODE_W-1:0] target_mode;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0]  cnt_arr [NUM_CNT];

    mrc_qualifier #(
        .MODE_W  (MODE_W),
        .RUN_W   (RUN_W),
        .DEF_MODE(DEF_MODE)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_mode   (det_mode),
        .det_valid  (det_valid),
        .cfg_runs   (cfg_runs),
        .stable_mode(stable_mode)
    );

    // R7: lock overrides the detected mode
    assign target_mode = cfg_lock ? cfg_lock_mode : stable_mode;

    mrc_sequencer #(
        .MODE_W  (MODE_W),
        .TIMEOUT (TIMEOUT),
        .DEF_MODE(DEF_MODE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .target_mode (target_mode),
        .hpd_evt     (hpd_evt),
        .edid_evt    (edid_evt),
        .frame_tick  (frame_tick),
        .tg_done     (tg_done),
        .err_clr     (stat_clear),
        .blank       (blank),
        .reconf_pulse(reconf_pulse),
        .reconf_mode (reconf_mode),
        .cur_mode    (cur_mode),
        .err_timeout (err_timeout)
    );

    always_comb begin
        inc_vec             = '0;
        inc_vec[IDX_RECONF] = reconf_pulse;
        inc_vec[IDX_UNDER]  = buf_underflow;
        inc_vec[IDX_OVER]   = buf_overflow;
        inc_vec[IDX_WMARK]  = buf_watermark;
    end

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        mrc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc_vec[gi]),
            .clr  (stat_clear),
            .count(cnt_arr[gi])
        );
    end

    assign cnt_reconfig  = cnt_arr[IDX_RECONF];
    assign cnt_underflow = cnt_arr[IDX_UNDER];
    assign cnt_overflow  = cnt_arr[IDX_OVER];
    assign cnt_watermark = cnt_arr[IDX_WMARK];

    // R7: while locked and settings unchanged, detect samples start nothing
    a_r7_lock_ignores_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && $past(cfg_lock) && $stable(cfg_lock_mode)) |-> $stable(target_mode));
endmodule

// File: tb/test_mode_reconfig_ctrl.sv
module test_mode_reconfig_ctrl;
    localparam int MW = 4;
    localparam int RW = 4;
    localparam int CW = 8;
    localparam int TO = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [MW-1:0] det_mode = '0;
    logic          det_valid = 1'b0;
    logic          hpd_evt = 1'b0, edid_evt = 1'b0, frame_tick = 1'b0, tg_done = 1'b0;
    logic          buf_underflow = 1'b0, buf_overflow = 1'b0, buf_watermark = 1'b0;
    logic [RW-1:0] cfg_runs = RW'(3);
    logic          cfg_lock = 1'b0;
    logic [MW-1:0] cfg_lock_mode = '0;
    logic          stat_clear = 1'b0;
    logic          blank, reconf_pulse, err_timeout;
    logic [MW-1:0] reconf_mode, cur_mode;
    logic [CW-1:0] cnt_reconfig, cnt_underflow, cnt_overflow, cnt_watermark;

    mode_reconfig_ctrl #(.MODE_W(MW), .RUN_W(RW), .CNT_W(CW), .TIMEOUT(TO), .DEF_MODE(0)) i_mode_reconfig_ctrl (
        .clk(clk), .rst_n(rst_n), .det_mode(det_mode), .det_valid(det_valid),
        .hpd_evt(hpd_evt), .edid_evt(edid_evt), .frame_tick(frame_tick), .tg_done(tg_done),
        .buf_underflow(buf_underflow), .buf_overflow(buf_overflow), .buf_watermark(buf_watermark),
        .cfg_runs(cfg_runs), .cfg_lock(cfg_lock), .cfg_lock_mode(cfg_lock_mode),
        .stat_clear(stat_clear), .blank(blank), .reconf_pulse(reconf_pulse),
        .reconf_mode(reconf_mode), .cur_mode(cur_mode), .err_timeout(err_timeout),
        .cnt_reconfig(cnt_reconfig), .cnt_underflow(cnt_underflow),
        .cnt_overflow(cnt_overflow), .cnt_watermark(cnt_watermark)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [MW-1:0] exp_q [$];

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample(input int m);
        det_mode = MW'(m); det_valid = 1'b1; step(1); det_valid = 1'b0;
    endtask

    // driver: push expectation, then walk the blank/tick/strobe/done order
    task automatic run_reconf(input int m);
        exp_q.push_back(MW'(m));
        step(3);
        check("R5 blank raised before frame tick", int'(blank), 1);
        frame_tick = 1'b1; step(1); frame_tick = 1'b0;
        step(2);
        check("R5 blank held until done", int'(blank), 1);
        tg_done = 1'b1; step(1); tg_done = 1'b0;
        step(2);
        check("R5 blank released after done", int'(blank), 0);
        check("R10 cur_mode after reconfig", int'(cur_mode), m);
    endtask

    // monitor: pop and compare each strobe
    always @(negedge clk) begin
        if (rst_n && reconf_pulse) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3 unexpected strobe actual=%0d expected=none", reconf_mode);
            end else begin
                check("R10 strobe mode", int'(reconf_mode), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3); rst_n = 1'b1; step(1);
        check("R1 blank", int'(blank), 1);
        check("R1 strobe", int'(reconf_pulse), 0);
        check("R1 err", int'(err_timeout), 0);
        check("R1 cur_mode", int'(cur_mode), 0);
        check("R1 counters", int'(cnt_reconfig) + int'(cnt_underflow) + int'(cnt_overflow) + int'(cnt_watermark), 0);

        step(5);
        check("R3 no start without trigger", int'(blank), 1);
        hpd_evt = 1'b1; step(1); hpd_evt = 1'b0;
        run_reconf(0);
        check("R8 reconfig count", int'(cnt_reconfig), 1);

        sample(5); sample(5); step(6);
        check("R2 two samples not enough", int'(cnt_reconfig), 1);
        check("R2 output still live", int'(blank), 0);
        sample(5);
        run_reconf(5);

        sample(7); sample(5); sample(5); sample(5); step(8);
        check("R4 glitch gives no reconfig", int'(cnt_reconfig), 2);
        check("R4 glitch keeps output live", int'(blank), 0);

        sample(9); step(4); sample(9); step(2);
        check("R2 valid gaps keep run open", int'(cnt_reconfig), 2);
        sample(9);
        run_reconf(9);
        sample(9); sample(9); sample(9); step(6);
        check("R4 repeated mode no second reconfig", int'(cnt_reconfig), 3);

        cfg_lock_mode = MW'(3); cfg_lock = 1'b1; step(1);
        run_reconf(3);
        sample(6); sample(6); sample(6); sample(6); step(6);
        check("R7 lock ignores detect", int'(cnt_reconfig), 4);
        check("R7 lock keeps mode", int'(cur_mode), 3);
        check("R7 lock output live", int'(blank), 0);
        cfg_lock = 1'b0; step(1);
        run_reconf(6);

        edid_evt = 1'b1; step(1); edid_evt = 1'b0;
        exp_q.push_back(MW'(6));
        step(2);
        frame_tick = 1'b1; step(1); frame_tick = 1'b0;
        step(TO + 8);
        check("R6 timeout sets error", int'(err_timeout), 1);
        check("R6 halt stays blanked", int'(blank), 1);
        step(10);
        check("R6 halt waits for trigger", int'(blank), 1);
        hpd_evt = 1'b1; step(1); hpd_evt = 1'b0;
        run_reconf(6);
        check("R6 error sticky", int'(err_timeout), 1);
        check("R8 reconfig total", int'(cnt_reconfig), 7);

        buf_underflow = 1'b1; step(3); buf_underflow = 1'b0;
        buf_overflow = 1'b1; step(2); buf_overflow = 1'b0;
        buf_watermark = 1'b1; step(5); buf_watermark = 1'b0;
        step(1);
        check("R8 underflow count", int'(cnt_underflow), 3);
        check("R8 overflow count", int'(cnt_overflow), 2);
        check("R8 watermark count", int'(cnt_watermark), 5);

        stat_clear = 1'b1; step(1); stat_clear = 1'b0;
        check("R9 clear reconfig", int'(cnt_reconfig), 0);
        check("R9 clear underflow", int'(cnt_underflow), 0);
        check("R9 clear watermark", int'(cnt_watermark), 0);
        check("R9 clear error", int'(err_timeout), 0);

        buf_watermark = 1'b1; step(300); buf_watermark = 1'b0; step(1);
        check("R8 watermark saturates", int'(cnt_watermark), 255);
        check("R8 overflow untouched", int'(cnt_overflow), 0);

        step(4);
        check("R4 all expected strobes seen", exp_q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule